// File: doc/BRIEF.md
# Dimension-Ordered Multicast Chain Splitter

This block carries out a single step of a multicast that is built from plain point-to-point transfers. The caller supplies a fixed table of up to 16 node addresses of an 8x8 mesh. It also supplies a window into that table, given as a start index and a length, and the absolute index of the node that holds the packet now. On a start strobe the block cuts the window into a lower and an upper half. It chooses the node that the holder sends the packet to in this step. It returns two smaller windows: one goes with the forwarded packet and the other stays with the holder.

A controller calls the block again for every window that is longer than one node. Every node that already holds a copy takes part in the next round at the same time. With N destinations, the tree completes after ceil(log2 N) rounds, counted from a holder that is itself in the list. Because the block only passes table indexes around, a step never copies addresses. It also checks that the window is a proper chain and flags an error if not.

Top module: `mc_chain_split`

## Requirements
- R1: While reset is asserted and after it is released, `step_vld_o`, `done_o` and `err_o` are low and every index, length and address output is zero, until the first start.
- R2: Entry i occupies `chain_i[6*i +: 6]`, with x in bits [5:3] and y in bits [2:0]. Order compares x first and looks at y only when the x values are equal.
- R3: A window is a valid chain only when its entries never decrease, or never increase, along the sequence. Equal neighbours are allowed. Entries outside the window are ignored. An unordered window, a zero length, a window that runs past entry 15, or a holder outside the window raises `err_o`, with all index and length outputs zero and `done_o` low.
- R4: Each start strobe yields `step_vld_o` high in exactly the next cycle, carrying that start's result. Without a start, `step_vld_o` is low. Results hold until the next start.
- R5: For a window of length 1, `done_o` is high, the forwarded length is 0, the kept window is (base, 1), and the target index equals the holder.
- R6: For length L ≥ 2, the lower half is the first floor(L/2) entries from the base, and the upper half is the remaining entries.
- R7: A holder in the lower half forwards to the first entry of the upper half. The forwarded window is the upper half and the kept window is the lower half.
- R8: A holder in the upper half forwards to the last entry of the lower half. The forwarded window is the lower half and the kept window is the upper half.
- R9: For a window of two entries, the target is the entry that is not the holder, and each side keeps one node.
- R10: `target_o` is the address stored at the target index.
- R11: Repeated steps starting from any holder in an N-entry list reach every entry exactly once, in ceil(log2 N) rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one split step |
| chain_i | input | 96 | Address table, 16 entries of {x,y} |
| base_i | input | 4 | First index of the window |
| len_i | input | 5 | Window length, 0 to 16 |
| holder_i | input | 4 | Absolute index of the current holder |
| step_vld_o | output | 1 | One-cycle result strobe |
| target_o | output | 6 | Address of the forwarding target |
| target_idx_o | output | 4 | Table index of the target |
| fwd_base_o | output | 4 | Base of the forwarded window |
| fwd_len_o | output | 5 | Length of the forwarded window |
| keep_base_o | output | 4 | Base of the kept window |
| keep_len_o | output | 5 | Length of the kept window |
| done_o | output | 1 | Window was a single node |
| err_o | output | 1 | Bad window or unordered chain |

## Verification
The order check and the split decision are evaluated in the same cycle, so a single start must resolve both. Windows that are well ordered but carry an out-of-window holder, and windows that contain a swapped pair only outside their range, show whether the error takes precedence and whether the check stays inside the window. A second start can also arrive in the very cycle that the previous result is showing. The bench issues two starts back to back and judges each result in its own cycle, and it checks that the strobe drops one cycle after the last start.

// File: rtl/mc_chain_pkg.sv
package mc_chain_pkg;
  parameter int unsigned MC_COORD_W = 3;
  parameter int unsigned MC_ENTRIES = 16;

  localparam int unsigned ENT_W   = 2 * MC_COORD_W;
  localparam int unsigned CHAIN_W = ENT_W * MC_ENTRIES;
  localparam int unsigned IDX_W   = $clog2(MC_ENTRIES);
  localparam int unsigned LEN_W   = $clog2(MC_ENTRIES + 1);
  localparam int unsigned SPAN_W  = LEN_W + 1;

  typedef logic [ENT_W-1:0] entry_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    logic err;
    logic done;
    idx_t tgt_idx;
    idx_t fwd_base;
    len_t fwd_len;
    idx_t keep_base;
    len_t keep_len;
  } step_t;

  function automatic logic [MC_COORD_W-1:0] coord_x(entry_t e);
    return e[ENT_W-1 -: MC_COORD_W];
  endfunction

  function automatic logic [MC_COORD_W-1:0] coord_y(entry_t e);
    return e[MC_COORD_W-1:0];
  endfunction

  // Lexicographic order: x decides, y breaks ties.
  function automatic logic key_le(entry_t a, entry_t b);
    if (coord_x(a) != coord_x(b)) return coord_x(a) < coord_x(b);
    return coord_y(a) <= coord_y(b);
  endfunction

  function automatic len_t lower_len(len_t l);
    return l >> 1;
  endfunction
endpackage

// File: rtl/mc_order_check.sv
module mc_order_check
  import mc_chain_pkg::*;
(
  input  logic [CHAIN_W-1:0] chain_i,
  input  idx_t               base_i,
  input  len_t               len_i,
  output logic               rise_ok_o,
  output logic               fall_ok_o
);
  localparam int unsigned PAIRS = MC_ENTRIES - 1;

  logic [SPAN_W-1:0] win_end;
  logic [PAIRS-1:0]  up_ok;
  logic [PAIRS-1:0]  dn_ok;

  assign win_end = SPAN_W'(base_i) + SPAN_W'(len_i);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    entry_t a, b;
    logic   in_win;
    assign a      = chain_i[p*ENT_W +: ENT_W];
    assign b      = chain_i[(p+1)*ENT_W +: ENT_W];
    assign in_win = (SPAN_W'(p) >= SPAN_W'(base_i)) && (SPAN_W'(p + 1) < win_end);
    assign up_ok[p] = !in_win || key_le(a, b);
    assign dn_ok[p] = !in_win || key_le(b, a);
  end

  assign rise_ok_o = &up_ok;
  assign fall_ok_o = &dn_ok;
endmodule

// File: rtl/mc_split_calc.sv
module mc_split_calc
  import mc_chain_pkg::*;
(
  input  idx_t  base_i,
  input  len_t  len_i,
  input  idx_t  holder_i,
  input  logic  ordered_i,
  output logic  holder_upper_o,
  output logic  bad_window_o,
  output step_t res_o
);
  len_t              lo_len;
  len_t              hi_len;
  logic [SPAN_W-1:0] hi_base;
  logic [SPAN_W-1:0] win_end;
  logic              bad_len;
  logic              bad_hold;

  assign lo_len   = lower_len(len_i);
  assign hi_len   = len_i - lo_len;
  assign hi_base  = SPAN_W'(base_i) + SPAN_W'(lo_len);
  assign win_end  = SPAN_W'(base_i) + SPAN_W'(len_i);
  assign bad_len  = (len_i == '0) || (win_end > SPAN_W'(MC_ENTRIES));
  assign bad_hold = (holder_i < base_i) || (SPAN_W'(holder_i) >= win_end);

  assign holder_upper_o = SPAN_W'(holder_i) >= hi_base;
  assign bad_window_o   = bad_len || bad_hold;

  always_comb begin
    res_o = '0;
    if (bad_window_o || !ordered_i) begin
      res_o.err = 1'b1;
    end else if (len_i == LEN_W'(1)) begin
      res_o.done      = 1'b1;
      res_o.tgt_idx   = holder_i;
      res_o.fwd_base  = base_i;
      res_o.keep_base = base_i;
      res_o.keep_len  = LEN_W'(1);
    end else if (holder_upper_o) begin
      res_o.tgt_idx   = IDX_W'(hi_base - SPAN_W'(1));
      res_o.fwd_base  = base_i;
      res_o.fwd_len   = lo_len;
      res_o.keep_base = IDX_W'(hi_base);
      res_o.keep_len  = hi_len;
    end else begin
      res_o.tgt_idx   = IDX_W'(hi_base);
      res_o.fwd_base  = IDX_W'(hi_base);
      res_o.fwd_len   = hi_len;
      res_o.keep_base = base_i;
      res_o.keep_len  = lo_len;
    end
  end
endmodule

// File: rtl/mc_entry_pick.sv
module mc_entry_pick
  import mc_chain_pkg::*;
(
  input  logic [CHAIN_W-1:0] chain_i,
  input  idx_t               idx_i,
  output entry_t             entry_o
);
  assign entry_o = chain_i[idx_i*ENT_W +: ENT_W];
endmodule

// File: rtl/mc_chain_split.sv
module mc_chain_split
  import mc_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CHAIN_W-1:0] chain_i,
  input  logic [IDX_W-1:0]   base_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [IDX_W-1:0]   holder_i,
  output logic               step_vld_o,
  output logic [ENT_W-1:0]   target_o,
  output logic [IDX_W-1:0]   target_idx_o,
  output logic [IDX_W-1:0]   fwd_base_o,
  output logic [LEN_W-1:0]   fwd_len_o,
  output logic [IDX_W-1:0]   keep_base_o,
  output logic [LEN_W-1:0]   keep_len_o,
  output logic               done_o,
  output logic               err_o
);
  logic   rise_ok, fall_ok, ordered;
  logic   holder_upper, bad_window;
  step_t  step_d, step_q;
  entry_t tgt_addr_d, tgt_addr_q;
  logic   vld_q;

  mc_order_check u_order (
    .chain_i   (chain_i),
    .base_i    (base_i),
    .len_i     (len_i),
    .rise_ok_o (rise_ok),
    .fall_ok_o (fall_ok)
  );

  assign ordered = rise_ok || fall_ok;

  mc_split_calc u_split (
    .base_i         (base_i),
    .len_i          (len_i),
    .holder_i       (holder_i),
    .ordered_i      (ordered),
    .holder_upper_o (holder_upper),
    .bad_window_o   (bad_window),
    .res_o          (step_d)
  );

  mc_entry_pick u_pick (
    .chain_i (chain_i),
    .idx_i   (step_d.tgt_idx),
    .entry_o (tgt_addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      step_q     <= '0;
      tgt_addr_q <= '0;
    end else begin
      vld_q <= start_i;
      if (start_i) begin
        step_q     <= step_d;
        tgt_addr_q <= step_d.err ? '0 : tgt_addr_d;
      end
    end
  end

  assign step_vld_o   = vld_q;
  assign target_o     = tgt_addr_q;
  assign target_idx_o = step_q.tgt_idx;
  assign fwd_base_o   = step_q.fwd_base;
  assign fwd_len_o    = step_q.fwd_len;
  assign keep_base_o  = step_q.keep_base;
  assign keep_len_o   = step_q.keep_len;
  assign done_o       = step_q.done;
  assign err_o        = step_q.err;

  AST_VLD_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> step_vld_o); // R4
  AST_VLD_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !step_vld_o); // R4
  AST_ERR_CLEARS_LENGTHS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (fwd_len_o == '0) && (keep_len_o == '0) && !done_o); // R3
  AST_BAD_WINDOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && bad_window |=> err_o); // R3
  AST_LEN_SPLIT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && !err_o |->
      (SPAN_W'(fwd_len_o) + SPAN_W'(keep_len_o)) == SPAN_W'($past(len_i))); // R6
  AST_LOWER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && !err_o && !done_o |->
      ((fwd_len_o < keep_len_o) ? fwd_len_o : keep_len_o) == ($past(len_i) >> 1)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && done_o |-> ($past(len_i) == LEN_W'(1)) && (fwd_len_o == '0)); // R5
  AST_TARGET_AT_SEAM: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && !err_o && !done_o |->
      ((fwd_base_o > keep_base_o) ? (target_idx_o == fwd_base_o)
        : (SPAN_W'(target_idx_o) == SPAN_W'(fwd_base_o) + SPAN_W'(fwd_len_o) - SPAN_W'(1)))); // R7
  AST_UPPER_HOLDER_FWD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && !err_o && !done_o && $past(holder_upper) |-> fwd_base_o < keep_base_o); // R8
  AST_HOLDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o && !err_o |->
      ($past(holder_i) >= keep_base_o) &&
      (SPAN_W'($past(holder_i)) < SPAN_W'(keep_base_o) + SPAN_W'(keep_len_o))); // R8
endmodule

// File: tb/mc_chain_split_tb.sv
module mc_chain_split_tb;
  import mc_chain_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {base4, len5, holder4, tgt4, fwd_base4, fwd_len5, keep_base4, keep_len5, done1, err1, req4}
  localparam logic [40:0] VECS [NVEC] = '{
    {4'd0, 5'd16, 4'd0, 4'd8, 4'd8, 5'd8, 4'd0, 5'd8, 1'b0, 1'b0, 4'd7},   // R7
    {4'd0, 5'd16, 4'd15, 4'd7, 4'd0, 5'd8, 4'd8, 5'd8, 1'b0, 1'b0, 4'd8},  // R8
    {4'd3, 5'd5, 4'd3, 4'd5, 4'd5, 5'd3, 4'd3, 5'd2, 1'b0, 1'b0, 4'd6},    // R6 odd
    {4'd3, 5'd5, 4'd7, 4'd4, 4'd3, 5'd2, 4'd5, 5'd3, 1'b0, 1'b0, 4'd8},    // R8
    {4'd10, 5'd2, 4'd11, 4'd10, 4'd10, 5'd1, 4'd11, 5'd1, 1'b0, 1'b0, 4'd9}, // R9
    {4'd10, 5'd2, 4'd10, 4'd11, 4'd11, 5'd1, 4'd10, 5'd1, 1'b0, 1'b0, 4'd9}, // R9
    {4'd6, 5'd1, 4'd6, 4'd6, 4'd6, 5'd0, 4'd6, 5'd1, 1'b1, 1'b0, 4'd5},    // R5
    {4'd2, 5'd4, 4'd9, 4'd0, 4'd0, 5'd0, 4'd0, 5'd0, 1'b0, 1'b1, 4'd3},    // R3 holder out
    {4'd12, 5'd5, 4'd12, 4'd0, 4'd0, 5'd0, 4'd0, 5'd0, 1'b0, 1'b1, 4'd3},  // R3 overrun
    {4'd0, 5'd0, 4'd0, 4'd0, 4'd0, 5'd0, 4'd0, 5'd0, 1'b0, 1'b1, 4'd3},    // R3 zero len
    {4'd5, 5'd3, 4'd6, 4'd5, 4'd5, 5'd1, 4'd6, 5'd2, 1'b0, 1'b0, 4'd8},    // R8 odd
    {4'd5, 5'd3, 4'd5, 4'd6, 4'd6, 5'd2, 4'd5, 5'd1, 1'b0, 1'b0, 4'd7}     // R7 odd
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [CHAIN_W-1:0] chain = '0;
  logic [IDX_W-1:0]   base = '0;
  logic [LEN_W-1:0]   len = '0;
  logic [IDX_W-1:0]   holder = '0;
  logic               step_vld, done, err;
  logic [ENT_W-1:0]   target;
  logic [IDX_W-1:0]   target_idx, fwd_base, keep_base;
  logic [LEN_W-1:0]   fwd_len, keep_len;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_chain_split u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chain_i(chain),
    .base_i(base), .len_i(len), .holder_i(holder),
    .step_vld_o(step_vld), .target_o(target), .target_idx_o(target_idx),
    .fwd_base_o(fwd_base), .fwd_len_o(fwd_len), .keep_base_o(keep_base),
    .keep_len_o(keep_len), .done_o(done), .err_o(err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] node(input int x, input int y);
    return {3'(x), 3'(y)};
  endfunction

  task automatic fill_ascending();
    for (int i = 0; i < 16; i++) chain[i*6 +: 6] = node(i / 2, (i % 2 == 1) ? 5 : 2);
  endtask

  task automatic step(input int b, input int l, input int h);
    @(negedge clk);
    base = 4'(b); len = 5'(l); holder = 4'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [40:0] result_vec();
    return {target_idx, fwd_base, fwd_len, keep_base, keep_len, done, err};
  endfunction

  function automatic int ref_rounds(input int n);
    int r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  task automatic run_tree(input int n, input int start_holder);
    int ib[16], il[16], ih[16], cnt;
    int nb[16], nl[16], nh[16], nc;
    int rounds, hits[16];
    bit any;
    cnt = 1; ib[0] = 0; il[0] = n; ih[0] = start_holder; rounds = 0;
    for (int r = 0; r < 8; r++) begin
      any = 1'b0; nc = 0;
      for (int k = 0; k < cnt; k++) begin
        if (il[k] > 1) begin
          any = 1'b1;
          step(ib[k], il[k], ih[k]);
          check("R11 step error", err, 0);
          check("R11 target inside forwarded window",
                (target_idx >= fwd_base) && (target_idx < fwd_base + fwd_len), 1);
          nb[nc] = keep_base; nl[nc] = keep_len; nh[nc] = ih[k]; nc++;
          nb[nc] = fwd_base;  nl[nc] = fwd_len;  nh[nc] = target_idx; nc++;
        end else begin
          nb[nc] = ib[k]; nl[nc] = il[k]; nh[nc] = ih[k]; nc++;
        end
      end
      if (!any) break;
      rounds++;
      cnt = (nc > 16) ? 16 : nc;
      for (int k = 0; k < cnt; k++) begin ib[k] = nb[k]; il[k] = nl[k]; ih[k] = nh[k]; end
    end
    for (int i = 0; i < 16; i++) hits[i] = 0;
    for (int k = 0; k < cnt; k++) if (il[k] == 1 && ih[k] == ib[k]) hits[ib[k]]++;
    check("R11 rounds", rounds, ref_rounds(n));
    for (int i = 0; i < n; i++) check("R11 node reached once", hits[i], 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    fill_ascending();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in and after reset
    check("R1 reset outputs", {step_vld, done, err, target, target_idx, fwd_len, keep_len}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 after release", {step_vld, done, err, fwd_base, keep_base, fwd_len, keep_len}, 0);

    // Table walk: R5 R6 R7 R8 R9 R3, plus R10 target address
    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      v = VECS[i];
      step(v[40:37], v[36:32], v[31:28]);
      check($sformatf("R%0d vec %0d valid", v[3:0], i), step_vld, 1);
      check($sformatf("R%0d vec %0d result", v[3:0], i), result_vec(), {4'b0, v[27:4]});
      if (!v[4])
        check("R10 target address", target, chain[v[27:24]*6 +: 6]);
    end

    // R4: strobe lasts one cycle, results hold
    @(negedge clk);
    check("R4 strobe drops", step_vld, 0);
    check("R4 result held", {target_idx, fwd_len, keep_len}, {4'd6, 5'd2, 5'd1});

    // R4: back-to-back starts, each judged in its own cycle
    @(negedge clk);
    base = 0; len = 16; holder = 3; start = 1'b1;
    @(negedge clk);
    base = 3; len = 5; holder = 7;
    check("R4 first of pair", {step_vld, target_idx, fwd_base, fwd_len}, {1'b1, 4'd8, 4'd8, 5'd8});
    @(negedge clk);
    start = 1'b0;
    check("R4 second of pair", {step_vld, target_idx, fwd_base, fwd_len}, {1'b1, 4'd4, 4'd3, 5'd2});
    @(negedge clk);
    check("R4 strobe after pair", step_vld, 0);

    // R3: descending chain is valid
    for (int i = 0; i < 16; i++) chain[i*6 +: 6] = node(7 - i / 2, (i % 2 == 1) ? 1 : 6);
    step(0, 8, 0);
    check("R3 descending accepted", result_vec(), {4'd4, 4'd4, 5'd4, 4'd0, 5'd4, 1'b0, 1'b0});
    // R3: equal neighbours allowed
    for (int i = 0; i < 16; i++) chain[i*6 +: 6] = node(3, 3);
    step(2, 6, 7);
    check("R3 equal entries", {err, target_idx}, {1'b0, 4'd4});
    // R3: disorder inside and outside the window
    fill_ascending();
    chain[4*6 +: 6] = node(2, 5);
    chain[5*6 +: 6] = node(2, 2);
    step(0, 16, 0);
    check("R3 swapped pair in window", err, 1);
    check("R3 error clears lengths", {fwd_len, keep_len, done}, 0);
    step(6, 4, 6);
    check("R3 swap outside window ignored", {err, target_idx, fwd_len}, {1'b0, 4'd8, 5'd2});

    // R2: x compared before y
    fill_ascending();
    chain[0*6 +: 6] = node(1, 2);
    chain[1*6 +: 6] = node(1, 5);
    chain[2*6 +: 6] = node(2, 0);
    step(0, 3, 0);
    check("R2 x-first order accepted", {err, target_idx}, {1'b0, 4'd1});
    check("R2 target address fields", target, 6'b001_101);
    chain[0*6 +: 6] = node(0, 7);
    chain[1*6 +: 6] = node(1, 0);
    chain[2*6 +: 6] = node(0, 5);
    step(0, 3, 0);
    check("R2 mixed order rejected", err, 1);

    // R11: full recursion for several sizes and holders
    fill_ascending();
    run_tree(1, 0);
    run_tree(2, 1);
    run_tree(3, 2);
    run_tree(5, 0);
    run_tree(8, 5);
    run_tree(13, 12);
    run_tree(16, 0);
    run_tree(16, 9);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule